// File: doc/BRIEF.md
# Accumulator with Extend Bit and Operation Logic

This block is the working register of a single-accumulator datapath. It holds a 16-bit accumulator value and a one-bit extend flag, and on each rising clock edge it replaces them with the result of one operation. The control unit picks that operation by asserting exactly one of nine enable inputs:

- AND, add, load and increment, which use an external 16-bit operand (increment does not).
- Load of an 8-bit character into the low byte.
- Complement, shift right and shift left.
- Clear.

The accumulator value and the extend flag are always visible on the outputs. The surrounding control logic raises one enable for one cycle per micro-operation. The operand and character inputs only need to be valid in that cycle. The adder is shared between the add and increment paths. The shifts rotate through the extend flag, so a run of shifts moves the flag through the whole 17-bit loop.

Top module: `acc_datapath`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets the accumulator to 0x0000 and the extend flag to 0 at that edge.
- R2: In a cycle with no enable asserted, the accumulator and the extend flag keep their values.
- R3: With and_en, the accumulator becomes the bitwise AND of its old value and opnd_i; the extend flag is unchanged.
- R4: With add_en, the accumulator becomes the low 16 bits of old accumulator plus opnd_i, and the extend flag becomes the carry out of bit 15.
- R5: With ld_opnd_en, the accumulator becomes opnd_i; the extend flag is unchanged.
- R6: With ld_char_en, accumulator bits 7..0 become char_i and bits 15..8 become 0; the extend flag is unchanged.
- R7: With cpl_en, every accumulator bit is inverted; the extend flag is unchanged.
- R8: With shr_en, accumulator bit 15 takes the old extend flag, bits 14..0 take old bits 15..1, and the extend flag takes old bit 0.
- R9: With shl_en, accumulator bit 0 takes the old extend flag, bits 15..1 take old bits 14..0, and the extend flag takes old bit 15.
- R10: With clr_en, the accumulator becomes 0x0000; the extend flag is unchanged.
- R11: With inc_en, the accumulator becomes old value plus one modulo 2^16 (0xFFFF wraps to 0x0000); the extend flag is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| and_en | input | 1 | AND accumulator with operand |
| add_en | input | 1 | Add operand, carry into extend flag |
| ld_opnd_en | input | 1 | Load operand into accumulator |
| ld_char_en | input | 1 | Load character into low byte, clear high byte |
| cpl_en | input | 1 | Complement accumulator |
| shr_en | input | 1 | Rotate right through extend flag |
| shl_en | input | 1 | Rotate left through extend flag |
| clr_en | input | 1 | Clear accumulator |
| inc_en | input | 1 | Increment accumulator |
| opnd_i | input | 16 | Data operand |
| char_i | input | 8 | Input character |
| acc_o | output | 16 | Accumulator value |
| ext_o | output | 1 | Extend flag |

## Verification
The checker assumes that the control unit raises at most one enable in any cycle. It flags a breach of this assumption as a violation instead of defining a winner. Every other assertion ties one enable to the registered result one edge later. These assertions rely on operand and character being stable across the sampling edge. The directed bench drives all inputs on the falling edge, raises a single enable per step and lowers it before the next step. The operand values are chosen to reach the carry, wrap and rotate boundaries.

// File: rtl/acc_pkg.sv
package acc_pkg;
    localparam int ACC_W  = 16;
    localparam int CHAR_W = 8;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             ext;
    } acc_state_t;

    localparam acc_state_t ACC_RESET = '{acc: '0, ext: 1'b0};
endpackage

// File: rtl/acc_logic_unit.sv
module acc_logic_unit #(
    parameter int W = 16
) (
    input  logic [W-1:0] acc,
    input  logic [W-1:0] opnd,
    output logic [W-1:0] and_res,
    output logic [W-1:0] cpl_res
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        assign and_res[b] = acc[b] & opnd[b];
        assign cpl_res[b] = ~acc[b];
    end
endmodule

// File: rtl/acc_adder.sv
module acc_adder #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] carry;
    assign carry[0] = 1'b0;

    for (genvar b_i = 0; b_i < W; b_i++) begin : g_fa
        assign sum[b_i]     = a[b_i] ^ b[b_i] ^ carry[b_i];
        assign carry[b_i+1] = (a[b_i] & b[b_i]) | (carry[b_i] & (a[b_i] ^ b[b_i]));
    end

    assign cout = carry[W];
endmodule

// File: rtl/acc_rotator.sv
module acc_rotator #(
    parameter int W = 16
) (
    input  logic [W-1:0] acc,
    input  logic         ext,
    output logic [W-1:0] right_acc,
    output logic         right_ext,
    output logic [W-1:0] left_acc,
    output logic         left_ext
);
    assign right_acc = {ext, acc[W-1:1]};
    assign right_ext = acc[0];
    assign left_acc  = {acc[W-2:0], ext};
    assign left_ext  = acc[W-1];
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
    import acc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              and_en,
    input  logic              add_en,
    input  logic              ld_opnd_en,
    input  logic              ld_char_en,
    input  logic              cpl_en,
    input  logic              shr_en,
    input  logic              shl_en,
    input  logic              clr_en,
    input  logic              inc_en,
    input  logic [ACC_W-1:0]  opnd_i,
    input  logic [CHAR_W-1:0] char_i,
    output logic [ACC_W-1:0]  acc_o,
    output logic              ext_o
);
    localparam int HI_W = ACC_W - CHAR_W;

    acc_state_t state_q, state_d;

    logic [ACC_W-1:0] and_res, cpl_res, sum_res, add_b;
    logic [ACC_W-1:0] shr_acc, shl_acc;
    logic             sum_cout, shr_ext, shl_ext;

    acc_logic_unit #(.W(ACC_W)) u_logic (
        .acc     (state_q.acc),
        .opnd    (opnd_i),
        .and_res (and_res),
        .cpl_res (cpl_res)
    );

    // Increment shares the adder: second input is one instead of the operand.
    assign add_b = inc_en ? ACC_W'(1) : opnd_i;

    acc_adder #(.W(ACC_W)) u_adder (
        .a    (state_q.acc),
        .b    (add_b),
        .sum  (sum_res),
        .cout (sum_cout)
    );

    acc_rotator #(.W(ACC_W)) u_rot (
        .acc       (state_q.acc),
        .ext       (state_q.ext),
        .right_acc (shr_acc),
        .right_ext (shr_ext),
        .left_acc  (shl_acc),
        .left_ext  (shl_ext)
    );

    always_comb begin
        state_d = state_q;
        unique case (1'b1)
            and_en:     state_d.acc = and_res;
            add_en:     begin
                            state_d.acc = sum_res;
                            state_d.ext = sum_cout;
                        end
            ld_opnd_en: state_d.acc = opnd_i;
            ld_char_en: state_d.acc = {{HI_W{1'b0}}, char_i};
            cpl_en:     state_d.acc = cpl_res;
            shr_en:     begin
                            state_d.acc = shr_acc;
                            state_d.ext = shr_ext;
                        end
            shl_en:     begin
                            state_d.acc = shl_acc;
                            state_d.ext = shl_ext;
                        end
            clr_en:     state_d.acc = '0;
            inc_en:     state_d.acc = sum_res;
            default:    ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ACC_RESET;
        else     state_q <= state_d;
    end

    assign acc_o = state_q.acc;
    assign ext_o = state_q.ext;
endmodule

// File: rtl/acc_datapath_chk.sv
module acc_datapath_chk (
    input logic        clk,
    input logic        rst,
    input logic        and_en,
    input logic        add_en,
    input logic        ld_opnd_en,
    input logic        ld_char_en,
    input logic        cpl_en,
    input logic        shr_en,
    input logic        shl_en,
    input logic        clr_en,
    input logic        inc_en,
    input logic [15:0] opnd_i,
    input logic [7:0]  char_i,
    input logic [15:0] acc_o,
    input logic        ext_o
);
    logic [8:0] ens;
    logic       none_en;
    assign ens = {and_en, add_en, ld_opnd_en, ld_char_en, cpl_en, shr_en, shl_en, clr_en, inc_en};
    assign none_en = (ens == 9'd0);

    a_one_enable: assert property (@(posedge clk) disable iff (rst) $onehot0(ens));

    a_r1_reset: assert property (@(posedge clk) rst |=> (acc_o == 16'h0000 && !ext_o));

    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        none_en |=> ($stable(acc_o) && $stable(ext_o)));

    a_r3_and: assert property (@(posedge clk) disable iff (rst)
        and_en |=> (acc_o == ($past(acc_o) & $past(opnd_i)) && $stable(ext_o)));

    a_r4_add: assert property (@(posedge clk) disable iff (rst)
        add_en |=> ({ext_o, acc_o} == ({1'b0, $past(acc_o)} + {1'b0, $past(opnd_i)})));

    a_r5_load: assert property (@(posedge clk) disable iff (rst)
        ld_opnd_en |=> (acc_o == $past(opnd_i) && $stable(ext_o)));

    a_r6_char: assert property (@(posedge clk) disable iff (rst)
        ld_char_en |=> (acc_o == {8'h00, $past(char_i)} && $stable(ext_o)));

    a_r7_cpl: assert property (@(posedge clk) disable iff (rst)
        cpl_en |=> (acc_o == ~$past(acc_o) && $stable(ext_o)));

    a_r8_shr: assert property (@(posedge clk) disable iff (rst)
        shr_en |=> ({acc_o, ext_o} == {$past(ext_o), $past(acc_o)}));

    a_r9_shl: assert property (@(posedge clk) disable iff (rst)
        shl_en |=> ({ext_o, acc_o} == {$past(acc_o), $past(ext_o)}));

    a_r10_clr: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> (acc_o == 16'h0000 && $stable(ext_o)));

    a_r11_inc: assert property (@(posedge clk) disable iff (rst)
        inc_en |=> (acc_o == $past(acc_o) + 16'd1 && $stable(ext_o)));
endmodule

bind acc_datapath acc_datapath_chk u_chk (
    .clk(clk), .rst(rst), .and_en(and_en), .add_en(add_en),
    .ld_opnd_en(ld_opnd_en), .ld_char_en(ld_char_en), .cpl_en(cpl_en),
    .shr_en(shr_en), .shl_en(shl_en), .clr_en(clr_en), .inc_en(inc_en),
    .opnd_i(opnd_i), .char_i(char_i), .acc_o(acc_o), .ext_o(ext_o)
);

// File: tb/acc_datapath_tb_top.sv
`timescale 1ns/1ps
module acc_datapath_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        and_en = 0, add_en = 0, ld_opnd_en = 0, ld_char_en = 0, cpl_en = 0;
    logic        shr_en = 0, shl_en = 0, clr_en = 0, inc_en = 0;
    logic [15:0] opnd_i = '0;
    logic [7:0]  char_i = '0;
    logic [15:0] acc_o;
    logic        ext_o;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_acc;
    logic        exp_ext;

    always #2 clk = ~clk;

    acc_datapath dut_i (.*);

    typedef enum int {OP_NONE, OP_AND, OP_ADD, OP_LDO, OP_LDC, OP_CPL, OP_SHR, OP_SHL, OP_CLR, OP_INC} op_t;

    task automatic check(string req);
        checks++;
        if (acc_o !== exp_acc || ext_o !== exp_ext) begin
            errors++;
            $display("FAIL %s: acc=%h ext=%b expected acc=%h ext=%b", req, acc_o, ext_o, exp_acc, exp_ext);
        end
    endtask

    // Drive one operation at the falling edge, let one rising edge pass, update the model.
    task automatic step(op_t op, logic [15:0] d, logic [7:0] c, string req);
        logic [16:0] s;
        @(negedge clk);
        opnd_i = d; char_i = c;
        and_en = (op == OP_AND); add_en = (op == OP_ADD); ld_opnd_en = (op == OP_LDO);
        ld_char_en = (op == OP_LDC); cpl_en = (op == OP_CPL); shr_en = (op == OP_SHR);
        shl_en = (op == OP_SHL); clr_en = (op == OP_CLR); inc_en = (op == OP_INC);
        case (op)
            OP_AND: exp_acc = exp_acc & d;
            OP_ADD: begin s = {1'b0, exp_acc} + {1'b0, d}; exp_acc = s[15:0]; exp_ext = s[16]; end
            OP_LDO: exp_acc = d;
            OP_LDC: exp_acc = {8'h00, c};
            OP_CPL: exp_acc = ~exp_acc;
            OP_SHR: begin s = {exp_ext, exp_acc}; exp_acc = s[16:1]; exp_ext = s[0]; end
            OP_SHL: begin s = {exp_acc, exp_ext}; exp_ext = s[16]; exp_acc = s[15:0]; end
            OP_CLR: exp_acc = 16'h0000;
            OP_INC: exp_acc = exp_acc + 16'd1;
            default: ;
        endcase
        @(posedge clk);
        #1;
        check(req);
        @(negedge clk);
        {and_en, add_en, ld_opnd_en, ld_char_en, cpl_en, shr_en, shl_en, clr_en, inc_en} = '0;
    endtask

    task automatic t_reset;
        step(OP_LDO, 16'hBEEF, 8'h00, "R5");
        step(OP_SHL, 16'h0000, 8'h00, "R9");
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        exp_acc = 16'h0000; exp_ext = 1'b0;
        check("R1");
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_hold;
        step(OP_LDO, 16'h5A5A, 8'h00, "R5");
        step(OP_NONE, 16'hFFFF, 8'hFF, "R2");
        step(OP_NONE, 16'h0000, 8'h00, "R2");
    endtask

    task automatic t_and_cpl;
        step(OP_LDO, 16'hF0F0, 8'h00, "R5");
        step(OP_AND, 16'h3C3C, 8'h00, "R3");
        step(OP_CPL, 16'h0000, 8'h00, "R7");
        step(OP_CPL, 16'h0000, 8'h00, "R7");
    endtask

    task automatic t_add;
        step(OP_LDO, 16'h1234, 8'h00, "R5");
        step(OP_ADD, 16'h1111, 8'h00, "R4");
        step(OP_LDO, 16'hFFFF, 8'h00, "R5");
        step(OP_ADD, 16'h0001, 8'h00, "R4");
        step(OP_ADD, 16'h0000, 8'h00, "R4");
        step(OP_LDO, 16'h8000, 8'h00, "R5");
        step(OP_ADD, 16'h8000, 8'h00, "R4");
    endtask

    task automatic t_char;
        step(OP_LDO, 16'hFFFF, 8'h00, "R5");
        step(OP_LDC, 16'hAAAA, 8'hA5, "R6");
        step(OP_LDC, 16'h0000, 8'hFF, "R6");
    endtask

    task automatic t_shift;
        step(OP_CLR, 16'h0000, 8'h00, "R10");
        step(OP_CPL, 16'h0000, 8'h00, "R7");
        step(OP_ADD, 16'h0001, 8'h00, "R4");
        step(OP_LDO, 16'h8001, 8'h00, "R5");
        step(OP_SHR, 16'h0000, 8'h00, "R8");
        step(OP_SHR, 16'h0000, 8'h00, "R8");
        step(OP_SHL, 16'h0000, 8'h00, "R9");
        step(OP_SHL, 16'h0000, 8'h00, "R9");
        for (int i = 0; i < 17; i++) step(OP_SHL, 16'h0000, 8'h00, "R9");
        step(OP_LDO, 16'h0003, 8'h00, "R5");
        for (int i = 0; i < 3; i++) step(OP_SHR, 16'h0000, 8'h00, "R8");
    endtask

    task automatic t_clr_inc;
        step(OP_LDO, 16'hFFFE, 8'h00, "R5");
        step(OP_INC, 16'h1234, 8'h00, "R11");
        step(OP_INC, 16'h1234, 8'h00, "R11");
        step(OP_INC, 16'h0000, 8'h00, "R11");
        step(OP_LDO, 16'h7777, 8'h00, "R5");
        step(OP_CLR, 16'hFFFF, 8'hFF, "R10");
    endtask

    initial begin
        exp_acc = 16'h0000; exp_ext = 1'b0;
        repeat (2) @(posedge clk);
        #1; check("R1");
        @(negedge clk); rst = 1'b0;
        t_hold();
        t_and_cpl();
        t_add();
        t_char();
        t_shift();
        t_clr_inc();
        t_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        checks++; errors++;
        $display("FAIL watchdog: acc=%h ext=%b expected completion", acc_o, ext_o);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule